// File: doc/BRIEF.md
# Flash Write-Protect Region Checker

This block stands in front of the program and erase engine of a 128 KB serial flash array of 32 uniform 4 KB sectors. Each cycle it may receive one request: a page program, a 4 KB sector erase, a 32 KB or 64 KB block erase, a whole-array erase, or a status register write. It receives the target address with each request. From three block-protect bits, a status-register-lock bit and the active-low write-protect pin, it decides whether the request may proceed. One cycle later it presents the verdict on two separate grant lines. One line covers array operations and the other covers status register writes.

The protected window always ends at the top of the array. Its size grows with the 3-bit protect code, from nothing up to the full array. An erase is refused if any byte of the range it would clear lies in the window. A page program is judged by the base of its 256-byte page. Any refusal sets a sticky fault flag. The flag stays set until a status register write is accepted, which is the natural point for firmware to reconsider the protection setup.

Top module: `wp_region_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid_o`, `array_ok_o`, `status_ok_o` and `fault_o` are all 0.
- R2: A request sampled at a rising edge with `req_valid_i` = 1 produces `rsp_valid_o` = 1 and its verdict after that same edge. A cycle without a request gives `rsp_valid_o` = 0 with both grant lines 0.
- R3: The protect code `bp_i` selects a window that ends at address 0x1FFFF. The window sizes are: 000 none, 001 4 KB, 010 8 KB, 011 32 KB, 100 64 KB, 101 96 KB, 110 and 111 the whole 128 KB.
- R4: A page program (`op_i` = 0) is granted if and only if its page base (`addr_i` with bits 7:0 cleared) lies below the window. The low 8 address bits have no effect on the verdict.
- R5: A sector erase (`op_i` = 1, 4 KB aligned), a 32 KB block erase (`op_i` = 2) and a 64 KB block erase (`op_i` = 3) each cover the aligned range that contains `addr_i`. Each is refused if any byte of that range lies in the window.
- R6: A whole-array erase (`op_i` = 4) is granted only when `bp_i` = 000.
- R7: A status register write (`op_i` = 5) is refused exactly when `wp_n_i` = 0 and `srp_i` = 1. `wp_n_i` and `srp_i` have no effect on array operations.
- R8: Op codes 6 and 7 are reserved. They are answered with `rsp_valid_o` = 1 and both grant lines 0, and they count as refusals.
- R9: Every refused request sets `fault_o`, visible in the same cycle as its response. `fault_o` then stays set through granted array operations and refused requests.
- R10: An accepted status write clears `fault_o` in the cycle of its response. `array_ok_o` is only ever 1 for op codes 0 to 4, and `status_ok_o` only for op code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is present this cycle |
| op_i | input | 3 | Operation code (0 page, 1 sector, 2 32 KB block, 3 64 KB block, 4 whole array, 5 status write) |
| addr_i | input | 17 | Target byte address |
| bp_i | input | 3 | Protect-window size code |
| srp_i | input | 1 | Status register lock bit |
| wp_n_i | input | 1 | Write-protect pin, active low |
| rsp_valid_o | output | 1 | Verdict for the previous cycle's request |
| array_ok_o | output | 1 | Array operation granted |
| status_ok_o | output | 1 | Status register write granted |
| fault_o | output | 1 | Sticky refusal flag |

## Verification
Every result of this block is due exactly one clock after the request is sampled. This holds for the response strobe, both grant lines and the fault flag. The bench drives a request at a falling edge and removes it at the next falling edge. It reads all four outputs at that point, half a period after the registering edge. The cycle that follows is also read, to confirm that no verdict lingers. The protection inputs are held steady across each request, so each verdict depends only on the values present at the sampling edge.

// File: rtl/wp_guard_pkg.sv
`timescale 1ns/1ps
package wp_guard_pkg;

  typedef enum logic [2:0] {
    OP_PAGE   = 3'd0,
    OP_SECTOR = 3'd1,
    OP_BLK_S  = 3'd2,
    OP_BLK_L  = 3'd3,
    OP_WHOLE  = 3'd4,
    OP_STATUS = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } wp_op_e;

  // number of protected sectors for a window code, given the sector count
  function automatic int unsigned window_sectors(input logic [2:0] code,
                                                 input int unsigned n_sec);
    case (code)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return n_sec / 4;
      3'd4:    return n_sec / 2;
      3'd5:    return (3 * n_sec) / 4;
      default: return n_sec;
    endcase
  endfunction

  // array-touching operations (the ones judged against the window)
  function automatic logic is_array_op(input logic [2:0] op);
    return (op <= OP_WHOLE);
  endfunction

endpackage

// File: rtl/wp_window_decode.sv
`timescale 1ns/1ps
module wp_window_decode
  import wp_guard_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 4096,
  parameter int unsigned NUM_SECTORS  = 32,
  localparam int unsigned ARRAY_BYTES = SECTOR_BYTES * NUM_SECTORS,
  localparam int unsigned ADDR_W      = $clog2(ARRAY_BYTES)
) (
  input  logic [2:0]      bp_i,
  output logic [ADDR_W:0] win_lo_o,   // first protected byte; ARRAY_BYTES when none
  output logic            win_any_o
);

  int unsigned sec_cnt;

  always_comb begin
    sec_cnt   = window_sectors(bp_i, NUM_SECTORS);
    win_lo_o  = (ADDR_W+1)'(ARRAY_BYTES - sec_cnt * SECTOR_BYTES);
    win_any_o = (sec_cnt != 0);
  end

  always_comb begin
    a_r3_window_bounds: assert (win_lo_o <= (ADDR_W+1)'(ARRAY_BYTES));
    a_r3_window_any: assert (win_any_o == (win_lo_o != (ADDR_W+1)'(ARRAY_BYTES)));
  end

endmodule

// File: rtl/wp_span_calc.sv
`timescale 1ns/1ps
module wp_span_calc
  import wp_guard_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 4096,
  parameter int unsigned NUM_SECTORS  = 32,
  parameter int unsigned PAGE_BYTES   = 256,
  parameter int unsigned BLK_S_BYTES  = 32768,
  parameter int unsigned BLK_L_BYTES  = 65536,
  localparam int unsigned ARRAY_BYTES = SECTOR_BYTES * NUM_SECTORS,
  localparam int unsigned ADDR_W      = $clog2(ARRAY_BYTES),
  localparam int unsigned NUM_KINDS   = 5
) (
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] span_lo_o,
  output logic [ADDR_W-1:0] span_hi_o,
  output logic              span_ok_o   // op touches the array
);

  // one offset mask per array op kind, indexed by op code
  logic [ADDR_W-1:0] kind_mask [NUM_KINDS];

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_mask
    localparam int unsigned LEN =
      (k == 0) ? PAGE_BYTES   :
      (k == 1) ? SECTOR_BYTES :
      (k == 2) ? BLK_S_BYTES  :
      (k == 3) ? BLK_L_BYTES  : ARRAY_BYTES;
    assign kind_mask[k] = ADDR_W'(LEN - 1);
  end

  logic [ADDR_W-1:0] mask_sel;

  always_comb begin
    span_ok_o = is_array_op(op_i);
    mask_sel  = span_ok_o ? kind_mask[op_i] : '0;
    span_lo_o = addr_i & ~mask_sel;
    span_hi_o = addr_i | mask_sel;
  end

  always_comb begin
    a_r5_span_order: assert (span_lo_o <= span_hi_o);
  end

endmodule

// File: rtl/wp_status_gate.sv
`timescale 1ns/1ps
module wp_status_gate
  import wp_guard_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       srp_i,
  input  logic       wp_n_i,
  output logic       is_status_o,
  output logic       status_pass_o
);

  logic locked;

  always_comb begin
    is_status_o   = (op_i == OP_STATUS);
    locked        = srp_i & ~wp_n_i;
    status_pass_o = is_status_o & ~locked;
  end

endmodule

// File: rtl/wp_region_guard.sv
`timescale 1ns/1ps
module wp_region_guard
  import wp_guard_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 4096,
  parameter int unsigned NUM_SECTORS  = 32,
  parameter int unsigned PAGE_BYTES   = 256,
  parameter int unsigned BLK_S_BYTES  = 32768,
  parameter int unsigned BLK_L_BYTES  = 65536,
  localparam int unsigned ARRAY_BYTES = SECTOR_BYTES * NUM_SECTORS,
  localparam int unsigned ADDR_W      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        bp_i,
  input  logic              srp_i,
  input  logic              wp_n_i,
  output logic              rsp_valid_o,
  output logic              array_ok_o,
  output logic              status_ok_o,
  output logic              fault_o
);

  logic [ADDR_W:0]   win_lo;
  logic              win_any;
  logic [ADDR_W-1:0] span_lo, span_hi;
  logic              span_ok;
  logic              is_status, status_pass;

  wp_window_decode #(
    .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS)
  ) u_win (
    .bp_i(bp_i), .win_lo_o(win_lo), .win_any_o(win_any)
  );

  wp_span_calc #(
    .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS),
    .PAGE_BYTES(PAGE_BYTES), .BLK_S_BYTES(BLK_S_BYTES), .BLK_L_BYTES(BLK_L_BYTES)
  ) u_span (
    .op_i(op_i), .addr_i(addr_i),
    .span_lo_o(span_lo), .span_hi_o(span_hi), .span_ok_o(span_ok)
  );

  wp_status_gate u_sr (
    .op_i(op_i), .srp_i(srp_i), .wp_n_i(wp_n_i),
    .is_status_o(is_status), .status_pass_o(status_pass)
  );

  // named events, used by the registers and the assertions
  logic overlap_c, array_pass_c, deny_evt, clear_evt;

  always_comb begin
    overlap_c    = win_any && ({1'b0, span_hi} >= win_lo);
    array_pass_c = span_ok && !overlap_c;
    deny_evt     = req_valid_i && !array_pass_c && !status_pass;
    clear_evt    = req_valid_i && status_pass;
  end

  logic [2:0] rsp_op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      array_ok_o  <= 1'b0;
      status_ok_o <= 1'b0;
      fault_o     <= 1'b0;
      rsp_op_q    <= 3'd0;
    end else begin
      rsp_valid_o <= req_valid_i;
      array_ok_o  <= req_valid_i && array_pass_c;
      status_ok_o <= req_valid_i && status_pass;
      rsp_op_q    <= op_i;
      if (clear_evt)     fault_o <= 1'b0;
      else if (deny_evt) fault_o <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (!array_ok_o && !status_ok_o));

  a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({array_ok_o, status_ok_o}));

  a_r10_grant_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (array_ok_o |-> rsp_op_q <= 3'd4) and (status_ok_o |-> rsp_op_q == 3'd5));

  a_r6_whole_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i == 3'd4 && bp_i != 3'd0) |=> !array_ok_o);

  a_r7_status_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i == 3'd5 && !wp_n_i && srp_i) |=> !status_ok_o);

  a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && bp_i[2:1] == 2'b11) |=> !array_ok_o);

  a_r8_reserved_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i[2:1] == 2'b11) |=> (rsp_valid_o && !array_ok_o && !status_ok_o && fault_o));

  a_r9_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !array_ok_o && !status_ok_o) |-> fault_o);

  a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !clear_evt) |=> fault_o);

  a_r10_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
    status_ok_o |-> !fault_o);

endmodule

// File: tb/tb_wp_region_guard.sv
`timescale 1ns/1ps
module tb_wp_region_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [16:0] addr_i = '0;
  logic [2:0]  bp_i = '0;
  logic        srp_i = 1'b0;
  logic        wp_n_i = 1'b1;
  logic        rsp_valid_o, array_ok_o, status_ok_o, fault_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit m_fault = 1'b0;   // bench model of the sticky flag

  always #5 clk = ~clk;

  wp_region_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .op_i(op_i),
    .addr_i(addr_i), .bp_i(bp_i), .srp_i(srp_i), .wp_n_i(wp_n_i),
    .rsp_valid_o(rsp_valid_o), .array_ok_o(array_ok_o),
    .status_ok_o(status_ok_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (op=%0d addr=%h bp=%0d)",
               req, act, exp, op_i, addr_i, bp_i);
    end
  endtask

  // independent model of the protect window, in bytes
  function automatic int win_bytes(input int code);
    case (code)
      0: return 0;
      1: return 4 * 1024;
      2: return 8 * 1024;
      3: return 32 * 1024;
      4: return 64 * 1024;
      5: return 96 * 1024;
      default: return 128 * 1024;
    endcase
  endfunction

  function automatic bit exp_array(input int op, input int addr, input int code);
    int len, last, lo;
    case (op)
      0: len = 256;
      1: len = 4096;
      2: len = 32768;
      3: len = 65536;
      4: len = 131072;
      default: return 1'b0;
    endcase
    lo   = (addr / len) * len;
    last = lo + len - 1;
    if (win_bytes(code) == 0) return 1'b1;
    return (last < 131072 - win_bytes(code));
  endfunction

  function automatic bit exp_status(input int op, input bit srp, input bit wpn);
    return (op == 5) && !(srp && !wpn);
  endfunction

  // drive one request at a falling edge, read its verdict one clock later
  task automatic send(input string req, input int op, input int addr,
                      input int code, input bit srp, input bit wpn);
    bit ea, es;
    @(negedge clk);
    op_i = 3'(op); addr_i = 17'(addr); bp_i = 3'(code);
    srp_i = srp; wp_n_i = wpn; req_valid_i = 1'b1;
    ea = exp_array(op, addr, code);
    es = exp_status(op, srp, wpn);
    if (es) m_fault = 1'b0;
    else if (!ea) m_fault = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk({req, " rsp_valid (R2)"}, int'(rsp_valid_o), 1);
    chk({req, " array_ok"}, int'(array_ok_o), int'(ea));
    chk({req, " status_ok (R10)"}, int'(status_ok_o), int'(es));
    chk({req, " fault (R9)"}, int'(fault_o), int'(m_fault));
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid in reset", int'(rsp_valid_o), 0);
    chk("R1 array_ok in reset", int'(array_ok_o), 0);
    chk("R1 status_ok in reset", int'(status_ok_o), 0);
    chk("R1 fault in reset", int'(fault_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid_o), 0);
    chk("R1 fault after reset", int'(fault_o), 0);
  endtask

  task automatic t_idle;
    send("R2 one request", 0, 17'h00100, 0, 0, 1);
    @(negedge clk);
    chk("R2 idle rsp_valid", int'(rsp_valid_o), 0);
    chk("R2 idle array_ok", int'(array_ok_o), 0);
    chk("R2 idle status_ok", int'(status_ok_o), 0);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 32; s++)
        send("R3 window sweep", 1, s * 4096 + 123, c, 0, 1);
  endtask

  task automatic t_page;
    send("R4 page below 4K window", 0, 17'h1EFFF, 1, 0, 1);
    send("R4 page at 4K window", 0, 17'h1F000, 1, 0, 1);
    send("R4 page top of array", 0, 17'h1F0FF, 1, 0, 1);
    send("R4 page below 96K window", 0, 17'h07FFF, 5, 0, 1);
    send("R4 page low bits ignored", 0, 17'h08001, 5, 0, 1);
    send("R4 page 8K edge", 0, 17'h1DFFF, 2, 0, 1);
    send("R4 page 8K inside", 0, 17'h1E000, 2, 0, 1);
  endtask

  task automatic t_blocks;
    send("R5 32K block overlap", 2, 17'h18000, 1, 0, 1);
    send("R5 32K block clear", 2, 17'h10000, 1, 0, 1);
    send("R5 64K block low clear", 3, 17'h0ABCD, 4, 0, 1);
    send("R5 64K block high hit", 3, 17'h10000, 4, 0, 1);
    send("R5 64K block partial overlap", 3, 17'h12345, 3, 0, 1);
    send("R5 32K clear under 32K window", 2, 17'h17FFF, 3, 0, 1);
    send("R5 sector at window edge", 1, 17'h17FFF, 3, 0, 1);
    send("R5 sector inside window", 1, 17'h18000, 3, 0, 1);
  endtask

  task automatic t_whole;
    for (int c = 0; c < 8; c++) send("R6 whole-array erase", 4, 17'h00000, c, 0, 1);
  endtask

  task automatic t_status;
    send("R7 status srp=0 wp low", 5, 0, 3, 0, 0);
    send("R7 status srp=1 wp high", 5, 0, 3, 1, 1);
    send("R7 status locked", 5, 0, 3, 1, 0);
    send("R7 array op ignores lock", 1, 17'h00000, 0, 1, 0);
    send("R7 whole erase ignores lock", 4, 17'h00000, 0, 1, 0);
  endtask

  task automatic t_reserved;
    send("R8 reserved 6", 6, 17'h00000, 0, 0, 1);
    send("R8 reserved 7", 7, 17'h00000, 0, 0, 1);
  endtask

  task automatic t_fault;
    send("R10 clear via status", 5, 0, 0, 0, 1);
    chk("R10 fault cleared", int'(fault_o), 0);
    send("R9 deny sets fault", 1, 17'h1F000, 1, 0, 1);
    chk("R9 fault set", int'(fault_o), 1);
    send("R9 granted op keeps fault", 1, 17'h00000, 1, 0, 1);
    chk("R9 fault held", int'(fault_o), 1);
    send("R9 locked status keeps fault", 5, 0, 1, 1, 0);
    chk("R9 fault held by refused status", int'(fault_o), 1);
    @(negedge clk);
    chk("R9 fault held idle", int'(fault_o), 1);
    send("R10 accepted status clears", 5, 0, 1, 1, 1);
    chk("R10 fault clear after status", int'(fault_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_codes();
    t_page();
    t_blocks();
    t_whole();
    t_status();
    t_reserved();
    t_fault();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule